// File: doc/BRIEF.md
# JTAG Byte-Stream Data Register

This block carries a two-way byte stream between a JTAG host and on-chip logic through one debug data register. Each time the host scans the register, it learns how many bytes the chip has waiting and how much room the block has for new bytes. In the same scan the host collects up to eight waiting bytes and delivers up to eight new ones, so one scan does both the flow-control exchange and the data movement.

The frame is 72 bits long and shifts least significant bit first: a header byte, then eight byte slots. The header the block returns has the waiting-byte count in its upper nibble and the free-space count in its lower nibble. In the host's header, the upper nibble is the number of slots it is writing. On the chip side there are two FIFOs. The upstream FIFO is filled by chip logic and read by the host. The downstream FIFO is filled by the host and drained by chip logic. Both chip-side ports use a valid/ready byte handshake. A chain mode lets the block sit behind other devices on a scan chain. In that mode it ignores incoming zeros until a start bit arrives.

The block takes capture, shift and update strobes from an external TAP controller, all in one clock domain. Counts are frozen at capture, and the FIFOs move only at update.

Top module: `dbg_stream_port`

## Requirements
- R1: After reset, `dnValid` is 0 and `upReady` is 1. The first scan returns header byte 0x08, meaning nothing is waiting and eight slots are free.
- R2: At a capture strobe the block loads the returned frame. Bits 7:4 hold min(upstream fill, 8) and bits 3:0 hold min(downstream free space, 8). Both counts come from the cycle before capture. Returned frame bit k appears on `tdo` before the (k+1)-th shift, with bit 0 first.
- R3: Returned slot k (frame bits 8+8k to 15+8k) holds the k-th oldest upstream byte when k is less than the reported count. Otherwise the slot is zero.
- R4: At the update strobe that closes a complete scan, exactly the reported number of bytes leave the upstream FIFO. Bytes that chip logic pushes during the scan stay in the FIFO.
- R5: The host's write count is taken from frame bits 7:4 and clamped to 8. Frame bits 3:0 from the host are ignored.
- R6: At update, min(write count, free count reported at capture) bytes enter the downstream FIFO, taken from host slots 0 upward. The remaining slots are dropped.
- R7: If an update follows a scan in which fewer than 72 frame bits were received, neither FIFO changes.
- R8: Frame bits shifted in after the 72nd, such as a trailing guard bit, have no effect.
- R9: When `chainMode` is 1 at capture, incoming zeros are skipped until the first 1. That start bit is discarded and the next 72 bits form the frame. If no start bit arrives, the update moves nothing. The returned stream still starts at the first shift.
- R10: `upReady` is 1 exactly while the upstream FIFO is not full. `dnValid` is 1 while the downstream FIFO is non-empty, and `dnData` is its oldest byte. That byte holds steady until it is taken with `dnReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the TAP strobes |
| rstN | input | 1 | Active-low synchronous reset |
| captureDr | input | 1 | Capture strobe for this data register |
| shiftDr | input | 1 | Shift strobe; one bit moves per cycle |
| updateDr | input | 1 | Update strobe; commits the scan |
| tdi | input | 1 | Serial data from the host |
| chainMode | input | 1 | 1 selects start-bit framing, sampled at capture |
| tdo | output | 1 | Serial data to the host |
| upValid | input | 1 | Chip logic offers an upstream byte |
| upData | input | 8 | Upstream byte |
| upReady | output | 1 | Upstream FIFO has space |
| dnValid | output | 1 | A downstream byte is available |
| dnData | output | 8 | Oldest downstream byte |
| dnReady | input | 1 | Chip logic takes the downstream byte |

## Verification
The assertions assume the TAP strobes arrive one at a time in the order capture, shifts, update, and that chip logic holds `upData` while `upValid` is waiting. They also assume the FIFO pointer arithmetic can rely on `DEPTH` being a power of two. The bench drives each strobe in its own cycle and keeps `dnReady` low during scans, except where a drain is the thing under test. It applies chip-side pushes only through the handshake, so the bulk moves at update never compete with an illegal chip-side transfer.

// File: rtl/jsp_pkg.sv
package jsp_pkg;
  localparam int FRAME_BITS = 72;
  localparam int SLOTS      = 8;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;
  localparam int HDR_W      = 2 * NIB_W;

  typedef struct packed {
    logic load;      // capture returned frame and counts
    logic outShift;  // advance returned stream
    logic inShift;   // accept one host frame bit
    logic commit;    // move bytes between FIFOs and frame
  } jspStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_RECV,
    ST_DONE
  } jspState_e;
endpackage

// File: rtl/jsp_ctrl.sv
module jsp_ctrl import jsp_pkg::*; #(
  parameter int FRAME = FRAME_BITS,
  parameter int CW    = $clog2(FRAME + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        updateDr,
  input  logic        tdi,
  input  logic        chainMode,
  output jspStrobes_t strobes
);
  jspState_e      state;
  logic [CW-1:0]  bitCnt;
  logic           doShift;
  logic           doUpdate;

  // capture outranks shift, shift outranks update
  assign doShift  = shiftDr && !captureDr;
  assign doUpdate = updateDr && !captureDr && !shiftDr;

  always_comb begin
    strobes          = '0;
    strobes.load     = captureDr;
    strobes.outShift = doShift;
    strobes.inShift  = doShift && (state == ST_RECV);
    strobes.commit   = doUpdate && (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (captureDr) begin
      state  <= chainMode ? ST_HUNT : ST_RECV;
      bitCnt <= '0;
    end else if (doShift) begin
      case (state)
        ST_HUNT: if (tdi) state <= ST_RECV;
        ST_RECV: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CW'(FRAME - 1)) state <= ST_DONE;
        end
        default: ;
      endcase
    end else if (doUpdate) begin
      state <= ST_IDLE;
    end
  end

  AST_COMMIT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !strobes.commit); // R7

endmodule

// File: rtl/jsp_fifo.sv
module jsp_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int BULK  = 8,
  parameter int PEEK  = 8,
  parameter int NW    = 4,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    oneWr,
  input  logic [W-1:0]            oneData,
  input  logic [NW-1:0]           bulkWrN,
  input  logic [BULK-1:0][W-1:0]  bulkData,
  input  logic                    oneRd,
  input  logic [NW-1:0]           bulkRdN,
  output logic [CW-1:0]           count,
  output logic [PEEK-1:0][W-1:0]  peek
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  // bulk and single writes never meet in one instance
  always_ff @(posedge clk) begin
    for (int i = 0; i < BULK; i++) begin
      if (NW'(i) < bulkWrN) mem[wrPtr + AW'(i)] <= bulkData[i];
    end
    if (oneWr) mem[wrPtr] <= oneData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(bulkWrN) + AW'(oneWr);
      rdPtr <= rdPtr + AW'(bulkRdN) + AW'(oneRd);
      count <= count + CW'(bulkWrN) + CW'(oneWr) - CW'(bulkRdN) - CW'(oneRd);
    end
  end

  always_comb begin
    for (int i = 0; i < PEEK; i++) peek[i] = mem[rdPtr + AW'(i)];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (int'(count) + int'(bulkWrN) + int'(oneWr)) <= (DEPTH + int'(bulkRdN) + int'(oneRd))); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (int'(bulkRdN) + int'(oneRd)) <= int'(count)); // R4

endmodule

// File: rtl/jsp_datapath.sv
module jsp_datapath import jsp_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  jspStrobes_t                  strobes,
  input  logic                         tdi,
  output logic                         tdo,
  input  logic [CW-1:0]                upCount,
  input  logic [SLOTS-1:0][BYTE_W-1:0] upPeek,
  input  logic [CW-1:0]                dnCount,
  output logic [NIB_W-1:0]             popN,
  output logic [NIB_W-1:0]             pushN,
  output logic [SLOTS-1:0][BYTE_W-1:0] pushData
);
  localparam int IN_W = FRAME_BITS - NIB_W;  // host low nibble is never stored

  logic [FRAME_BITS-1:0] outReg;
  logic [FRAME_BITS-1:0] loadVal;
  logic [IN_W-1:0]       inReg;
  logic [NIB_W-1:0]      availNow, freeNow;
  logic [NIB_W-1:0]      availCap, freeCap;
  logic [NIB_W-1:0]      hostCnt, hostClamp, acceptN;

  function automatic logic [NIB_W-1:0] satNib(input int v);
    if (v > SLOTS) return NIB_W'(SLOTS);
    return NIB_W'(v);
  endfunction

  always_comb begin
    availNow = satNib(int'(upCount));
    freeNow  = satNib(DEPTH - int'(dnCount));
  end

  always_comb begin
    loadVal                    = '0;
    loadVal[NIB_W-1:0]         = freeNow;
    loadVal[HDR_W-1:NIB_W]     = availNow;
    for (int k = 0; k < SLOTS; k++) begin
      if (NIB_W'(k) < availNow) loadVal[HDR_W + k*BYTE_W +: BYTE_W] = upPeek[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg   <= '0;
      availCap <= '0;
      freeCap  <= '0;
    end else if (strobes.load) begin
      outReg   <= loadVal;
      availCap <= availNow;
      freeCap  <= freeNow;
    end else if (strobes.outShift) begin
      outReg <= {1'b0, outReg[FRAME_BITS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) inReg <= '0;
    else if (strobes.inShift) inReg <= {tdi, inReg[IN_W-1:1]};
  end

  assign tdo = outReg[0];

  always_comb begin
    hostCnt   = inReg[NIB_W-1:0];
    hostClamp = (hostCnt > NIB_W'(SLOTS)) ? NIB_W'(SLOTS) : hostCnt;
    acceptN   = (hostClamp < freeCap) ? hostClamp : freeCap;
    pushN     = strobes.commit ? acceptN  : '0;
    popN      = strobes.commit ? availCap : '0;
    for (int k = 0; k < SLOTS; k++) pushData[k] = inReg[NIB_W + k*BYTE_W +: BYTE_W];
  end

  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> (int'(pushN) + int'(dnCount)) <= DEPTH); // R6

  AST_POP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> popN <= upCount); // R4

  AST_HDR_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (outReg[HDR_W-1:NIB_W] <= NIB_W'(SLOTS)) && (outReg[NIB_W-1:0] <= NIB_W'(SLOTS))); // R2

endmodule

// File: rtl/dbg_stream_port.sv
module dbg_stream_port import jsp_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       captureDr,
  input  logic       shiftDr,
  input  logic       updateDr,
  input  logic       tdi,
  input  logic       chainMode,
  output logic       tdo,
  input  logic       upValid,
  input  logic [7:0] upData,
  output logic       upReady,
  output logic       dnValid,
  output logic [7:0] dnData,
  input  logic       dnReady
);
  localparam int CW = $clog2(DEPTH + 1);

  jspStrobes_t                  strobes;
  logic [CW-1:0]                upCount, dnCount;
  logic [SLOTS-1:0][BYTE_W-1:0] upPeek;
  logic [0:0][BYTE_W-1:0]       dnPeek;
  logic [NIB_W-1:0]             popN, pushN;
  logic [SLOTS-1:0][BYTE_W-1:0] pushData;

  assign upReady = (upCount < CW'(DEPTH));
  assign dnValid = (dnCount != '0);
  assign dnData  = dnPeek[0];

  jsp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .chainMode(chainMode), .strobes(strobes)
  );

  jsp_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tdi(tdi), .tdo(tdo),
    .upCount(upCount), .upPeek(upPeek), .dnCount(dnCount),
    .popN(popN), .pushN(pushN), .pushData(pushData)
  );

  jsp_fifo #(.DEPTH(DEPTH), .W(BYTE_W), .BULK(SLOTS), .PEEK(SLOTS), .NW(NIB_W)) uUpFifo (
    .clk(clk), .rstN(rstN),
    .oneWr(upValid && upReady), .oneData(upData),
    .bulkWrN('0), .bulkData('0),
    .oneRd(1'b0), .bulkRdN(popN),
    .count(upCount), .peek(upPeek)
  );

  jsp_fifo #(.DEPTH(DEPTH), .W(BYTE_W), .BULK(SLOTS), .PEEK(1), .NW(NIB_W)) uDnFifo (
    .clk(clk), .rstN(rstN),
    .oneWr(1'b0), .oneData('0),
    .bulkWrN(pushN), .bulkData(pushData),
    .oneRd(dnValid && dnReady), .bulkRdN('0),
    .count(dnCount), .peek(dnPeek)
  );

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnReady) |=> (dnValid && $stable(dnData))); // R10

endmodule

// File: tb/tb_dbg_stream_port.sv
module tb_dbg_stream_port;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0, chainMode = 1'b0;
  logic tdo;
  logic upValid = 1'b0;
  logic [7:0] upData = '0;
  logic upReady, dnValid;
  logic [7:0] dnData;
  logic dnReady = 1'b0;

  int errors = 0;
  int checks = 0;

  logic [7:0] upQ[$];
  logic [7:0] dnQ[$];
  logic [7:0] pendBytes[$];
  bit pendCommit = 0;
  int pendPop = 0;

  always #5 clk = ~clk;

  dbg_stream_port #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .chainMode(chainMode), .tdo(tdo),
    .upValid(upValid), .upData(upData), .upReady(upReady),
    .dnValid(dnValid), .dnData(dnData), .dnReady(dnReady)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: model follows the inputs seen at the edge, compare at negedge
  task automatic step();
    bit upPush, dnPop, doCommit;
    @(posedge clk);
    upPush   = rstN && upValid && (upQ.size() < DEPTH);
    dnPop    = rstN && dnReady && (dnQ.size() > 0);
    doCommit = rstN && updateDr && pendCommit;
    if (dnPop) void'(dnQ.pop_front());
    if (doCommit) begin
      foreach (pendBytes[i]) dnQ.push_back(pendBytes[i]);
      for (int i = 0; i < pendPop; i++) void'(upQ.pop_front());
    end
    if (upPush) upQ.push_back(upData);
    if (updateDr) pendCommit = 0;
    @(negedge clk);
    check(upReady == (upQ.size() < DEPTH), "R10", "upReady", 64'(upReady), 64'(upQ.size() < DEPTH));
    check(dnValid == (dnQ.size() > 0), "R10", "dnValid", 64'(dnValid), 64'(dnQ.size() > 0));
    if (dnQ.size() > 0) check(dnData == dnQ[0], "R10", "dnData", 64'(dnData), 64'(dnQ[0]));
  endtask

  task automatic scan(input bit chain, input int lead, input bit sendStart, input int wcnt,
                      input logic [63:0] pay, input int nFrame, input int tail, input bit tailVal,
                      output logic [7:0] gotHdr);
    logic [71:0] hostFrame;
    logic [71:0] got;
    bit stream[$];
    int ea, ef, acc, n;
    logic [63:0] ep;
    logic [7:0] eh;
    bit full;
    // host low nibble carries junk that must be ignored (R5)
    hostFrame = {pay, 4'(wcnt), 4'hA};
    for (int i = 0; i < lead; i++) stream.push_back(1'b0);
    if (chain && sendStart) stream.push_back(1'b1);
    for (int i = 0; i < nFrame; i++) stream.push_back(hostFrame[i]);
    for (int i = 0; i < tail; i++) stream.push_back(tailVal);
    ea = (upQ.size() > 8) ? 8 : upQ.size();
    ef = ((DEPTH - dnQ.size()) > 8) ? 8 : (DEPTH - dnQ.size());
    ep = '0;
    for (int k = 0; k < ea; k++) ep[8*k +: 8] = upQ[k];
    eh = {4'(ea), 4'(ef)};
    chainMode = chain;
    captureDr = 1'b1;
    step();
    captureDr = 1'b0;
    got = '0;
    n = stream.size();
    for (int i = 0; i < n; i++) begin
      shiftDr = 1'b1;
      tdi = stream[i];
      if (i < 72) got[i] = tdo;
      step();
    end
    shiftDr = 1'b0;
    tdi = 1'b0;
    full = (nFrame >= 72) && (!chain || sendStart);
    acc = (wcnt > 8) ? 8 : wcnt;
    if (acc > ef) acc = ef;
    pendBytes.delete();
    if (full) for (int k = 0; k < acc; k++) pendBytes.push_back(pay[8*k +: 8]);
    pendPop = ea;
    pendCommit = full;
    updateDr = 1'b1;
    step();
    updateDr = 1'b0;
    step();
    if (n >= 72) begin
      check(got[7:0] == eh, "R2", "returned header", 64'(got[7:0]), 64'(eh));
      check(got[71:8] == ep, "R3", "returned slots", got[71:8], ep);
    end
    gotHdr = got[7:0];
  endtask

  task automatic pushUp(input int n, input logic [7:0] base);
    upValid = 1'b1;
    for (int i = 0; i < n; i++) begin
      upData = base + 8'(i);
      step();
    end
    upValid = 1'b0;
  endtask

  task automatic drainAll(input int want, input string req);
    int cnt = 0;
    dnReady = 1'b1;
    for (int i = 0; i < want + 3; i++) begin
      if (dnValid) cnt++;
      step();
    end
    dnReady = 1'b0;
    check(cnt == want, req, "bytes delivered downstream", 64'(cnt), 64'(want));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] h;
    repeat (3) step();
    rstN = 1'b1;
    step();
    check(upReady == 1'b1, "R1", "upReady after reset", 64'(upReady), 64'd1);
    check(dnValid == 1'b0, "R1", "dnValid after reset", 64'(dnValid), 64'd0);

    scan(0, 0, 0, 0, 64'h0, 72, 0, 0, h);
    check(h == 8'h08, "R1", "first header", 64'(h), 64'h08);

    // R5/R6: three bytes written with junk low nibble
    scan(0, 0, 0, 3, 64'h0000_0000_00C3_B2A1, 72, 0, 0, h);
    check(dnValid == 1'b1 && dnData == 8'hA1, "R6", "first written byte", 64'(dnData), 64'hA1);
    drainAll(3, "R6");

    // R10: fill upstream past full
    pushUp(10, 8'h30);
    check(upReady == 1'b0, "R10", "upReady when full", 64'(upReady), 64'd0);
    scan(0, 0, 0, 0, 64'h0, 72, 0, 0, h);
    check(h == 8'h88, "R2", "full upstream header", 64'(h), 64'h88);
    check(upReady == 1'b1, "R4", "upstream emptied by update", 64'(upReady), 64'd1);

    // R6: free-space limit and R5 clamp
    pushUp(3, 8'h50);
    scan(0, 0, 0, 8, 64'h1817_1615_1413_1211, 72, 0, 0, h);
    check(h == 8'h38, "R2", "mixed header", 64'(h), 64'h38);
    scan(0, 0, 0, 15, 64'hFFEE_DDCC_BBAA_9988, 72, 0, 0, h);
    check(h == 8'h00, "R6", "no room header", 64'(h), 64'h00);
    dnReady = 1'b1;
    step();
    step();
    dnReady = 1'b0;
    scan(0, 0, 0, 12, 64'h2827_2625_2423_2221, 72, 0, 0, h);
    check(h == 8'h02, "R5", "two free header", 64'(h), 64'h02);
    drainAll(8, "R5");

    // R7: truncated scan moves nothing
    pushUp(2, 8'h60);
    scan(0, 0, 0, 4, 64'h4444_4444_4444_4444, 40, 0, 0, h);
    check(dnValid == 1'b0, "R7", "no push on short scan", 64'(dnValid), 64'd0);
    scan(0, 0, 0, 0, 64'h0, 72, 0, 0, h);
    check(h == 8'h28, "R7", "upstream kept after short scan", 64'(h), 64'h28);

    // R8: trailing ones after the frame
    scan(0, 0, 0, 2, 64'h0000_0000_0000_5A5B, 72, 3, 1, h);
    check(h == 8'h08, "R8", "header with guard bits", 64'(h), 64'h08);
    drainAll(2, "R8");

    // R9: chain mode with leading zeros and a start bit
    pushUp(1, 8'h70);
    scan(1, 5, 1, 3, 64'h0000_0000_0033_2211, 72, 1, 0, h);
    check(h == 8'h18, "R9", "chain header", 64'(h), 64'h18);
    drainAll(3, "R9");

    // R9: chain mode without start bit commits nothing
    pushUp(1, 8'h71);
    scan(1, 80, 0, 5, 64'h0, 0, 0, 0, h);
    check(dnValid == 1'b0, "R9", "no push without start bit", 64'(dnValid), 64'd0);
    scan(1, 2, 1, 0, 64'h0, 72, 0, 0, h);
    check(h == 8'h18, "R9", "upstream kept without start bit", 64'(h), 64'h18);

    // R4: chip pushes during a scan survive the update
    upValid = 1'b1;
    upData = 8'h77;
    scan(0, 0, 0, 1, 64'h0000_0000_0000_00EE, 72, 0, 0, h);
    upValid = 1'b0;
    scan(0, 0, 0, 0, 64'h0, 72, 0, 0, h);
    drainAll(1, "R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule